// File: doc/BRIEF.md
# Sequential Time-Lock Key Chain Recovery

This block rebuilds the 64-bit unlock key of a chained time-lock puzzle. The puzzle is split into P segments. The first segment's seed is supplied in clear. Each later segment's seed is stored masked by the key built up so far. The block hashes the first seed with a mixing permutation to form the starting key. It then walks the remaining segments one at a time: it reads the masked seed, removes the mask with the running key, hashes the result, and XORs that hash into the key. A segment can only be unmasked once every earlier hash has been folded in, so the work cannot be spread over parallel cores.

The permutation keeps two 32-bit halves, lo (seed bits 31:0) and hi (seed bits 63:32). It runs a programmable number of rounds per segment, and each round is eight multiply-then-XOR steps. Every hash leaves the block on a strobed output together with its segment number, so that a later stage can derive a wide cipher key from the full list. The block reads the masked seeds through an indexed read port whose data returns one cycle after the address.

Top module: `tlk_chain_recover`

## Requirements
- R1: After reset, busy, done, errFlag and hashValid are 0 and finalKey is 0.
- R2: The first hash is H(firstSeed, roundCount). It is reported with hashValid=1 and hashIdx=1, and finalKey equals that hash in the same cycle.
- R3: For each segment i from 2 to P, the seed is encData XOR the running key, where encData is the read-port data for address i. The hash of that seed is reported with hashIdx=i. Hashes appear strictly in the order 1, 2, ..., P, one strobe per segment.
- R4: On each hash with index i≥2, the key becomes the previous key XOR hash[i]. When done rises without error, finalKey equals the XOR of hash[1..P] as defined by R2 and R3.
- R5: done is raised in the same cycle as the hashValid strobe of segment P. With P=1 this is the first hash, no masked seed is read, and finalKey equals hash[1].
- R6: A round count of 0 makes H the identity, so each hash equals its input seed.
- R7: The read port addresses masked seeds by segment number on encAddr (values 2..P). The data on encData is taken one clock after the address is presented, which matches a registered memory read.
- R8: A start pulse while busy=1 has no effect. The running job's hashes, its finalKey and errFlag are the same as if the pulse had not occurred.
- R9: A start with segCount=0 gives done=1 and errFlag=1 on the next cycle, with busy=0 and no hashValid. errFlag stays 1 until the next accepted start clears it.
- R10: done is a single-cycle pulse, and busy is 0 whenever done is 1. busy is 1 from the cycle after an accepted start with segCount≠0 until done.
- R11: H runs its round count times the step sequence below, where k = 0..7 and K0..K7 = 85EBCA6B, C2B2AE35, 9E3779B9, 27D4EB2F, ED5AD4BB, AC4C1B51, BF58476D, 94D049BB (hex). For even k: lo = lo*Kk mod 2^32, then hi ^= lo. For odd k: hi = hi*Kk mod 2^32, then lo ^= hi. The result is {hi, lo}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a recovery job (ignored while busy) |
| segCount | input | SEG_W | Number of segments P |
| roundCount | input | ROUND_W | Permutation rounds per segment |
| firstSeed | input | KEY_W | Unmasked seed of segment 1, taken at start |
| encAddr | output | SEG_W | Segment number of the masked seed to read |
| encData | input | KEY_W | Masked seed, valid one cycle after encAddr |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| errFlag | output | 1 | Last start had segCount=0 |
| finalKey | output | KEY_W | Running / final chained key |
| hashValid | output | 1 | Strobe: a segment hash is on hashValue |
| hashIdx | output | SEG_W | Segment number of the strobed hash |
| hashValue | output | KEY_W | Hash of the segment |

## Verification
The chain runs with several segment counts (1, 2, 4, 5 and the boundary 0) and round counts (0, 1, 2, 3). Each masked-seed memory is filled with distinct, vector-dependent words. A wrong read address, a read taken one cycle late, or a missing unmask shows up as a wrong hash at a specific index rather than only as a wrong final key. The zero-round case separates chaining errors from permutation errors, because every hash must then equal its own seed. A second start with P=0 injected mid-run shows whether a busy job can be disturbed or its error flag set.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  typedef struct packed {
    logic arm;          // latch job parameters, index := 1
    logic launchFirst;  // start permutation on the clear first seed
    logic launchChain;  // start permutation on unmasked chained seed
    logic captureHash;  // fold finished hash into key and report it
    logic advance;      // step to next segment index
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HASH,
    ST_FETCH,
    ST_LAUNCH
  } ctrlState_t;
endpackage

// File: rtl/tlk_delay_core.sv
module tlk_delay_core #(
  parameter int KEY_W   = 64,
  parameter int ROUND_W = 32,
  parameter int STEPS   = 8,
  parameter logic [STEPS*(KEY_W/2)-1:0] MUL_K = {
    32'h94D049BB, 32'hBF58476D, 32'hAC4C1B51, 32'hED5AD4BB,
    32'h27D4EB2F, 32'h9E3779B9, 32'hC2B2AE35, 32'h85EBCA6B}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               go,
  input  logic [KEY_W-1:0]   seedIn,
  input  logic [ROUND_W-1:0] rounds,
  output logic               fin,
  output logic [KEY_W-1:0]   result
);
  localparam int HALF_W = KEY_W / 2;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic [HALF_W-1:0]  lo, hi, loNext, hiNext, mulK;
  logic [ROUND_W-1:0] remRounds;
  logic [STEP_W-1:0]  stepIdx;
  logic               running;

  always_comb begin
    mulK = MUL_K[stepIdx*HALF_W +: HALF_W];
    if (!stepIdx[0]) begin
      loNext = lo * mulK;
      hiNext = hi ^ loNext;
    end else begin
      hiNext = hi * mulK;
      loNext = lo ^ hiNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lo        <= '0;
      hi        <= '0;
      remRounds <= '0;
      stepIdx   <= '0;
      running   <= 1'b0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        lo        <= seedIn[HALF_W-1:0];
        hi        <= seedIn[KEY_W-1:HALF_W];
        remRounds <= rounds;
        stepIdx   <= '0;
        running   <= 1'b1;
      end else if (running) begin
        if (remRounds == '0) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end else begin
          lo <= loNext;
          hi <= hiNext;
          if (stepIdx == LAST_STEP) begin
            stepIdx   <= '0;
            remRounds <= remRounds - 1'b1;
          end else begin
            stepIdx <= stepIdx + 1'b1;
          end
        end
      end
    end
  end

  assign result = {hi, lo};
endmodule

// File: rtl/tlk_chain_ctrl.sv
module tlk_chain_ctrl
  import tlk_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [SEG_W-1:0] segCount,
  input  logic             coreFin,
  input  logic             isLast,
  output ctrlStrobe_t      strobe,
  output logic             busy,
  output logic             done,
  output logic             errFlag
);
  ctrlState_t state, stateNext;
  logic       finishNow, errNow;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    finishNow = 1'b0;
    errNow    = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        if (segCount == '0) begin
          errNow = 1'b1;
        end else begin
          strobe.arm         = 1'b1;
          strobe.launchFirst = 1'b1;
          stateNext          = ST_HASH;
        end
      end
      ST_HASH: if (coreFin) begin
        strobe.captureHash = 1'b1;
        if (isLast) begin
          finishNow = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobe.advance = 1'b1;
          stateNext      = ST_FETCH;
        end
      end
      ST_FETCH: stateNext = ST_LAUNCH;
      ST_LAUNCH: begin
        strobe.launchChain = 1'b1;
        stateNext          = ST_HASH;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finishNow | errNow;
      if (errNow)          errFlag <= 1'b1;
      else if (strobe.arm) errFlag <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/tlk_chain_dp.sv
module tlk_chain_dp
  import tlk_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int ROUND_W = 32,
  parameter int KEY_W   = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [SEG_W-1:0]   segCount,
  input  logic [ROUND_W-1:0] roundCount,
  input  logic [KEY_W-1:0]   firstSeed,
  input  logic [KEY_W-1:0]   encData,
  input  logic [KEY_W-1:0]   coreResult,
  output logic               coreGo,
  output logic [KEY_W-1:0]   coreSeed,
  output logic [ROUND_W-1:0] coreRounds,
  output logic               isLast,
  output logic [SEG_W-1:0]   encAddr,
  output logic [KEY_W-1:0]   finalKey,
  output logic               hashValid,
  output logic [SEG_W-1:0]   hashIdx,
  output logic [KEY_W-1:0]   hashValue
);
  localparam logic [SEG_W-1:0] FIRST_IDX = SEG_W'(1);

  logic [SEG_W-1:0]   segIdx, segTotal;
  logic [ROUND_W-1:0] roundsHeld;
  logic [KEY_W-1:0]   keyReg;

  assign coreGo     = strobe.launchFirst | strobe.launchChain;
  assign coreSeed   = strobe.launchFirst ? firstSeed : (encData ^ keyReg);
  assign coreRounds = strobe.launchFirst ? roundCount : roundsHeld;
  assign isLast     = (segIdx == segTotal);
  assign encAddr    = segIdx;
  assign finalKey   = keyReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segIdx     <= '0;
      segTotal   <= '0;
      roundsHeld <= '0;
      keyReg     <= '0;
      hashValid  <= 1'b0;
      hashIdx    <= '0;
      hashValue  <= '0;
    end else begin
      hashValid <= strobe.captureHash;
      if (strobe.arm) begin
        segIdx     <= FIRST_IDX;
        segTotal   <= segCount;
        roundsHeld <= roundCount;
      end else if (strobe.advance) begin
        segIdx <= segIdx + 1'b1;
      end
      if (strobe.captureHash) begin
        keyReg    <= (segIdx == FIRST_IDX) ? coreResult : (keyReg ^ coreResult);
        hashIdx   <= segIdx;
        hashValue <= coreResult;
      end
    end
  end
endmodule

// File: rtl/tlk_chain_recover.sv
module tlk_chain_recover
  import tlk_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int ROUND_W = 32,
  parameter int KEY_W   = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [SEG_W-1:0]   segCount,
  input  logic [ROUND_W-1:0] roundCount,
  input  logic [KEY_W-1:0]   firstSeed,
  output logic [SEG_W-1:0]   encAddr,
  input  logic [KEY_W-1:0]   encData,
  output logic               busy,
  output logic               done,
  output logic               errFlag,
  output logic [KEY_W-1:0]   finalKey,
  output logic               hashValid,
  output logic [SEG_W-1:0]   hashIdx,
  output logic [KEY_W-1:0]   hashValue
);
  ctrlStrobe_t        strobe;
  logic               coreGo, coreFin, isLast;
  logic [KEY_W-1:0]   coreSeed, coreResult;
  logic [ROUND_W-1:0] coreRounds;

  tlk_chain_ctrl #(.SEG_W(SEG_W)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .segCount(segCount),
    .coreFin(coreFin), .isLast(isLast), .strobe(strobe),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  tlk_chain_dp #(.SEG_W(SEG_W), .ROUND_W(ROUND_W), .KEY_W(KEY_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .segCount(segCount),
    .roundCount(roundCount), .firstSeed(firstSeed), .encData(encData),
    .coreResult(coreResult), .coreGo(coreGo), .coreSeed(coreSeed),
    .coreRounds(coreRounds), .isLast(isLast), .encAddr(encAddr),
    .finalKey(finalKey), .hashValid(hashValid), .hashIdx(hashIdx),
    .hashValue(hashValue)
  );

  tlk_delay_core #(.KEY_W(KEY_W), .ROUND_W(ROUND_W)) core (
    .clk(clk), .rstN(rstN), .go(coreGo), .seedIn(coreSeed),
    .rounds(coreRounds), .fin(coreFin), .result(coreResult)
  );
endmodule

// File: rtl/tlk_chain_recover_chk.sv
module tlk_chain_recover_chk #(
  parameter int SEG_W = 8,
  parameter int KEY_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             errFlag,
  input logic [KEY_W-1:0] finalKey,
  input logic             hashValid,
  input logic [SEG_W-1:0] hashIdx,
  input logic [KEY_W-1:0] hashValue
);
  logic [KEY_W-1:0] prevKey;
  logic [SEG_W-1:0] lastIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevKey <= '0;
      lastIdx <= '0;
    end else if (hashValid) begin
      prevKey <= finalKey;
      lastIdx <= hashIdx;
    end
  end

  assert_first_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    hashValid && hashIdx == SEG_W'(1) |-> finalKey == hashValue);

  assert_hash_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    hashValid && hashIdx != SEG_W'(1) |-> hashIdx == lastIdx + 1'b1);

  assert_key_fold_R4: assert property (@(posedge clk) disable iff (!rstN)
    hashValid && hashIdx != SEG_W'(1) |-> finalKey == (prevKey ^ hashValue));

  assert_done_with_hash_R5: assert property (@(posedge clk) disable iff (!rstN)
    done && !errFlag |-> hashValid);

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !errFlag |=> !errFlag);

  assert_err_no_hash_R9: assert property (@(posedge clk) disable iff (!rstN)
    done && errFlag |-> !hashValid && !busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind tlk_chain_recover tlk_chain_recover_chk #(.SEG_W(SEG_W), .KEY_W(KEY_W)) chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .errFlag(errFlag), .finalKey(finalKey), .hashValid(hashValid),
  .hashIdx(hashIdx), .hashValue(hashValue)
);

// File: tb/tlk_chain_recover_test.sv
module tlk_chain_recover_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W = 8, ROUND_W = 32, KEY_W = 64;
  localparam int MEM_N = 1 << SEG_W;
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [SEG_W-1:0]   segs;
    logic [ROUND_W-1:0] rounds;
    logic [KEY_W-1:0]   seed;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{segs: 8'd3, rounds: 32'd2, seed: 64'h0123_4567_89AB_CDEF},
    '{segs: 8'd1, rounds: 32'd3, seed: 64'hDEAD_BEEF_CAFE_F00D},
    '{segs: 8'd4, rounds: 32'd1, seed: 64'h0000_0000_0000_0001},
    '{segs: 8'd2, rounds: 32'd0, seed: 64'hFFFF_0000_1234_5678},
    '{segs: 8'd5, rounds: 32'd2, seed: 64'h8000_0000_7FFF_FFFF}
  };

  logic               clk = 0, rstN = 0, start = 0;
  logic [SEG_W-1:0]   segCount = '0;
  logic [ROUND_W-1:0] roundCount = '0;
  logic [KEY_W-1:0]   firstSeed = '0;
  logic [SEG_W-1:0]   encAddr;
  logic [KEY_W-1:0]   encData = '0;
  logic               busy, done, errFlag, hashValid;
  logic [KEY_W-1:0]   finalKey, hashValue;
  logic [SEG_W-1:0]   hashIdx;

  logic [KEY_W-1:0] encMem [MEM_N];
  logic [KEY_W-1:0] gotHash [MEM_N];
  int gotCount, orderBad;
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) encData <= encMem[encAddr];

  tlk_chain_recover #(.SEG_W(SEG_W), .ROUND_W(ROUND_W), .KEY_W(KEY_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .segCount(segCount),
    .roundCount(roundCount), .firstSeed(firstSeed), .encAddr(encAddr),
    .encData(encData), .busy(busy), .done(done), .errFlag(errFlag),
    .finalKey(finalKey), .hashValid(hashValid), .hashIdx(hashIdx),
    .hashValue(hashValue)
  );

  function automatic logic [KEY_W-1:0] refHash(logic [KEY_W-1:0] s, int n);
    logic [31:0] k [8];
    logic [31:0] lo, hi;
    k = '{32'h85EBCA6B, 32'hC2B2AE35, 32'h9E3779B9, 32'h27D4EB2F,
          32'hED5AD4BB, 32'hAC4C1B51, 32'hBF58476D, 32'h94D049BB};
    lo = s[31:0];
    hi = s[63:32];
    for (int r = 0; r < n; r++)
      for (int j = 0; j < 8; j++)
        if (j % 2 == 0) begin lo = lo * k[j]; hi = hi ^ lo; end
        else            begin hi = hi * k[j]; lo = lo ^ hi; end
    return {hi, lo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [KEY_W-1:0] act,
                       input logic [KEY_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic fillMem(input int tag);
    for (int i = 0; i < MEM_N; i++)
      encMem[i] = (64'(i) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(tag) << 56) ^ 64'h5A5A_A5A5_0F0F_F0F0;
  endtask

  task automatic pulseStart(input logic [SEG_W-1:0] p, input logic [ROUND_W-1:0] r,
                            input logic [KEY_W-1:0] s);
    @(negedge clk);
    segCount = p; roundCount = r; firstSeed = s; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // wait for done at negedges, recording hashes; injectAt>0 pulses a P=0 start
  task automatic collect(input int injectAt);
    int n = 0;
    gotCount = 0;
    orderBad = 0;
    forever begin
      @(negedge clk);
      n++;
      start = (n == injectAt);
      if (n == injectAt) begin segCount = '0; firstSeed = ~firstSeed; end
      if (hashValid) begin
        if (int'(hashIdx) != gotCount + 1) orderBad++;
        gotHash[hashIdx] = hashValue;
        gotCount++;
      end
      if (done) break;
    end
    start = 0;
  endtask

  task automatic runVector(input vec_t v, input int injectAt, input string tag);
    logic [KEY_W-1:0] key, h, sd;
    int p = int'(v.segs);
    int r = int'(v.rounds);
    pulseStart(v.segs, v.rounds, v.seed);
    check(busy == 1'b1, {"R10 busy after start ", tag}, 64'(busy), 64'd1);
    collect(injectAt);
    check(busy == 1'b0 && errFlag == 1'b0, {"R10/R8 idle no error at done ", tag},
          64'({busy, errFlag}), 64'd0);
    check(hashValid == 1'b1 && int'(hashIdx) == p, {"R5 done with last hash ", tag},
          64'(hashIdx), 64'(p));
    check(gotCount == p && orderBad == 0, {"R3 hash count and order ", tag},
          64'(gotCount), 64'(p));
    key = refHash(v.seed, r);
    check(gotHash[1] == key, {"R2 first hash ", tag}, gotHash[1], key);
    if (r == 0) check(gotHash[1] == v.seed, {"R6 identity hash ", tag}, gotHash[1], v.seed);
    for (int i = 2; i <= p; i++) begin
      sd = encMem[i] ^ key;
      h = refHash(sd, r);
      check(gotHash[i] == h, {"R3 R7 chained hash ", tag}, gotHash[i], h);
      key = key ^ h;
    end
    check(finalKey == key, {"R4 final key ", tag}, finalKey, key);
    @(negedge clk);
    check(done == 1'b0, {"R10 done one cycle ", tag}, 64'(done), 64'd0);
    check(finalKey == key, {"R4 key held ", tag}, finalKey, key);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) begin encMem[i] = '0; gotHash[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && errFlag == 0 && hashValid == 0,
          "R1 reset flags", 64'({busy, done, errFlag, hashValid}), 64'd0);
    check(finalKey == '0, "R1 reset key", finalKey, 64'd0);
    rstN = 1;

    // R11 permutation sequence through the vector table
    for (int v = 0; v < NVEC; v++) begin
      fillMem(v + 1);
      runVector(VECS[v], 0, $sformatf("R11 vec%0d", v));
    end

    // R9 zero segments
    pulseStart('0, 32'd2, 64'h1111_2222_3333_4444);
    check(done == 1 && errFlag == 1 && busy == 0 && hashValid == 0,
          "R9 zero-segment error", 64'({done, errFlag, busy, hashValid}), 64'b1100);
    @(negedge clk);
    check(done == 0 && errFlag == 1, "R9 error held", 64'({done, errFlag}), 64'b01);

    // R8 start while busy (P=0 and new seed injected mid-run); also clears R9 flag
    fillMem(9);
    runVector('{segs: 8'd3, rounds: 32'd1, seed: 64'hA5A5_5A5A_C3C3_3C3C}, 7, "R8 inject");
    runVector('{segs: 8'd2, rounds: 32'd1, seed: 64'h0F0F_0F0F_F0F0_F0F0}, 20, "R8 inject late");

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule